// File: doc/BRIEF.md
# Byte Lane Difference-Sum and Masked Merge Unit

This unit operates on the four byte lanes of two 32-bit operands and performs one of two operations. In difference-sum mode it treats every byte as unsigned and takes, per lane, the distance between the two bytes. It adds the four distances and returns the total, zero-extended to 32 bits. In masked-merge mode a 4-bit mask chooses, lane by lane, whether the output byte comes from operand A or from operand B.

A caller presents the operands, the mask and the operation code, then raises `startPulse` for one cycle. The inputs are captured on that edge. The result is held in a register and shows up on the next clock edge, together with a valid strobe that lasts one cycle. The result register holds its value until the next start.

Top module: `lane_sad_merge`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to 0 and holds `resultValid` low.
- R2: When `startPulse` is high on a rising edge, `result` and `resultValid` update on that same edge. `resultValid` is high for exactly one cycle per start and is low in every other cycle.
- R3: With `opSel`=0 (difference-sum), each lane contributes the larger of its two unsigned bytes minus the smaller. Lanes are bits 7:0, 15:8, 23:16 and 31:24.
- R4: In difference-sum mode `result` equals the sum of the four lane distances, zero-extended to 32 bits. Bits 31:10 are always 0, because the maximum value is 1020.
- R5: With `opSel`=1 (masked merge), mask bit k controls lane k, which is bits 8k+7:8k. Bit 0 is the lowest byte and bit 3 the highest.
- R6: In masked-merge mode a set mask bit takes the lane from `opA` and a clear mask bit takes it from `opB`.
- R7: In masked-merge mode the mask is ignored unless `opSel`=1. In difference-sum mode the mask has no effect on `result`.
- R8: While `startPulse` is low, `result` holds its last value, even when the operands change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | Capture the inputs and produce a result |
| opSel | input | 1 | 0 = difference-sum, 1 = masked merge |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| laneMask | input | 4 | Per-lane select mask, bit k for lane k |
| result | output | 32 | Registered result |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
The checker assumes that `startPulse` is a clean synchronous level and that the operands are stable across the capturing edge. It makes no assumption about back-to-back starts. The stimulus includes runs of consecutive starts as well as idle gaps. The operands are drawn from `$urandom` with a fixed seed, and directed cases cover the lane extremes 0x00 and 0xFF, the 1020 maximum, and the all-zero and all-one masks. The bench changes inputs only at falling edges, so each start is seen on exactly one rising edge.

// File: rtl/lane_sad_merge_pkg.sv
package lane_sad_merge_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic {
    OP_DIFFSUM = 1'b0,
    OP_MERGE   = 1'b1
  } opKind_t;

  typedef struct packed {
    logic    loadEn;
    opKind_t kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/lane_sad_merge_ctrl.sv
module lane_sad_merge_ctrl
  import lane_sad_merge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startPulse,
  input  logic        opSel,
  output ctrlStrobe_t strobe,
  output logic        validOut
);
  always_comb begin
    strobe.loadEn = startPulse & ~rst;
    strobe.kind   = opSel ? OP_MERGE : OP_DIFFSUM;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= startPulse;
  end
endmodule

// File: rtl/lane_sad_merge_dp.sv
module lane_sad_merge_dp
  import lane_sad_merge_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [LW*NL-1:0] opA,
  input  logic [LW*NL-1:0] opB,
  input  logic [NL-1:0]    laneMask,
  output logic [LW*NL-1:0] resultOut
);
  localparam int WW    = LW * NL;
  localparam int SUM_W = LW + $clog2(NL) + 1;

  logic [LW-1:0]    laneDist [NL];
  logic [WW-1:0]    mergeWord;
  logic [SUM_W-1:0] distSum;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [LW-1:0] aB, bB;
    assign aB = opA[k*LW +: LW];
    assign bB = opB[k*LW +: LW];
    assign laneDist[k] = (aB > bB) ? (aB - bB) : (bB - aB);
    assign mergeWord[k*LW +: LW] = laneMask[k] ? aB : bB;
  end

  always_comb begin
    distSum = '0;
    for (int k = 0; k < NL; k++) distSum = distSum + SUM_W'(laneDist[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) resultOut <= '0;
    else if (strobe.loadEn)
      resultOut <= (strobe.kind == OP_MERGE) ? mergeWord : WW'(distSum);
  end
endmodule

// File: rtl/lane_sad_merge.sv
module lane_sad_merge
  import lane_sad_merge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startPulse,
  input  logic        opSel,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [3:0]  laneMask,
  output logic [31:0] result,
  output logic        resultValid
);
  ctrlStrobe_t strobe;

  lane_sad_merge_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startPulse(startPulse), .opSel(opSel),
    .strobe(strobe), .validOut(resultValid)
  );

  lane_sad_merge_dp #(.LW(LANE_W), .NL(LANES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .opA(opA), .opB(opB),
    .laneMask(laneMask), .resultOut(result)
  );
endmodule

// File: rtl/lane_sad_merge_chk.sv
module lane_sad_merge_chk (
  input logic        clk,
  input logic        rst,
  input logic        startPulse,
  input logic        opSel,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [3:0]  laneMask,
  input logic [31:0] result,
  input logic        resultValid
);
  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (result == 32'd0 && !resultValid));
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst) startPulse |=> resultValid);
  p_valid_only_start_r2: assert property (@(posedge clk) disable iff (rst) !startPulse |=> !resultValid);
  p_sum_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (startPulse && !opSel) |=> (result[31:10] == 22'd0 && result <= 32'd1020));
  p_merge_lane0_r6: assert property (@(posedge clk) disable iff (rst)
    (startPulse && opSel && laneMask[0]) |=> result[7:0] == $past(opA[7:0]));
  p_merge_lane3_r5: assert property (@(posedge clk) disable iff (rst)
    (startPulse && opSel && !laneMask[3]) |=> result[31:24] == $past(opB[31:24]));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (seenEdge && !startPulse) |=> $stable(result));
endmodule

bind lane_sad_merge lane_sad_merge_chk u_chk (
  .clk(clk), .rst(rst), .startPulse(startPulse), .opSel(opSel), .opA(opA),
  .opB(opB), .laneMask(laneMask), .result(result), .resultValid(resultValid)
);

// File: tb/lane_sad_merge_test.sv
module lane_sad_merge_test;
  logic clk = 1'b0;
  logic rst, startPulse, opSel;
  logic [31:0] opA, opB, result;
  logic [3:0] laneMask;
  logic resultValid;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  lane_sad_merge uut (.*);

  function automatic logic [31:0] refSum(input logic [31:0] a, input logic [31:0] b);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int x = a[k*8 +: 8];
      int y = b[k*8 +: 8];
      s += (x > y) ? x - y : y - x;
    end
    return 32'(s);
  endfunction

  function automatic logic [31:0] refMerge(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = m[k] ? a[k*8 +: 8] : b[k*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample result at next negedge
  task automatic runOp(input string req, input logic sel, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] m);
    logic [31:0] exp;
    exp = sel ? refMerge(a, b, m) : refSum(a, b);
    startPulse = 1'b1; opSel = sel; opA = a; opB = b; laneMask = m;
    @(negedge clk);
    startPulse = 1'b0;
    check({req, " result"}, result, exp);
    check("R2 valid high", {31'd0, resultValid}, 32'd1);
    @(negedge clk);
    check("R2 valid drops", {31'd0, resultValid}, 32'd0);
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; startPulse = 1'b0; opSel = 1'b0; opA = '0; opB = '0; laneMask = '0;
    @(negedge clk); @(negedge clk);
    check("R1 result", result, 32'd0);
    check("R1 valid", {31'd0, resultValid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    runOp("R3 lane order", 1'b0, 32'h0A_00_05_03, 32'h01_07_05_09, 4'h0); // 9+0+7+6=22
    check("R3 value", result, 32'd22);
    runOp("R4 max sum", 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'h0);
    check("R4 1020", result, 32'd1020);
    runOp("R4 max swapped", 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 4'hF);
    runOp("R7 mask no effect sum", 1'b0, 32'h1234_5678, 32'h8765_4321, 4'hA);
    check("R7 value", result, refSum(32'h1234_5678, 32'h8765_4321));
    runOp("R5 lane0 only", 1'b1, 32'hAAAA_AAAA, 32'h5555_5555, 4'h1);
    check("R5 value", result, 32'h5555_55AA);
    runOp("R6 all A", 1'b1, 32'hDEAD_BEEF, 32'h0102_0304, 4'hF);
    runOp("R6 all B", 1'b1, 32'hDEAD_BEEF, 32'h0102_0304, 4'h0);
    runOp("R5 lane3 only", 1'b1, 32'hAAAA_AAAA, 32'h5555_5555, 4'h8);

    held = result;
    opA = 32'hFFFF_0000; opB = 32'h1234_5678; opSel = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hold", result, held);

    for (int i = 0; i < 200; i++) begin
      logic s = 1'($urandom);
      runOp(s ? "R6 random" : "R4 random", s, $urandom, $urandom, 4'($urandom));
    end

    // back-to-back starts
    startPulse = 1'b1; opSel = 1'b0; opA = 32'h0000_0010; opB = '0;
    @(negedge clk);
    check("R2 b2b first", result, 32'd16);
    opSel = 1'b1; opA = 32'h1111_1111; opB = 32'h2222_2222; laneMask = 4'h6;
    @(negedge clk);
    startPulse = 1'b0;
    check("R2 b2b second", result, 32'h2211_1122);
    check("R2 b2b valid", {31'd0, resultValid}, 32'd1);

    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 reset again", result, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule